// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a logical address, given as a segment number and a byte offset within that segment, into a physical address. It walks two tables held in ordinary memory. The first is a segment table, whose location is given by a base-address input. Each segment entry gives a present flag, a modified flag, a length in bytes and the address of that segment's own page table. After a bounds check on the offset, the upper offset bits select a page entry in that table. The frame number in that entry is joined with the lower offset bits to form the physical address.

Requests arrive on a valid/ready handshake and results leave on another. Only one translation is in flight at a time. All table accesses share a single word-wide memory port. Reads on that port may take any number of cycles to return. When a translation is for a store, the block marks the segment entry and the page entry as modified by writing them back through the same port. It only does this when the flag is not already set. Three distinct fault codes tell an absent segment, an out-of-bounds offset and an absent page apart.

Top module: `segx_xlate`

## Requirements
- R1: `req_ready` is high only when no translation is in flight and no response is pending. A response stays on `rsp_valid`, `rsp_paddr` and `rsp_fault` without change until `rsp_ready` is seen high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R2: The segment table base and the request fields are sampled when the request is accepted. The segment entry's first word is read from byte address base + 8 × segment and its second word from base + 8 × segment + 4. In the first word, bit 31 is present, bit 30 is modified and bits 23:0 are the segment length in bytes. The second word is the page table's byte address.
- R3: If the segment entry's present bit is 0, the response carries fault code 01 and physical address 0. No further memory access is made. This outcome wins over every other fault.
- R4: An offset greater than or equal to the segment length gives fault code 10 and physical address 0. No memory access follows the first word read, so no page table read is made.
- R5: The page number is offset bits 23:12. The page entry is read from page-table address + 4 × page number. In the page entry, bit 31 is present, bit 30 is modified and bits 19:0 are the frame number.
- R6: A page entry whose present bit is 0 gives fault code 11 and physical address 0, with no write.
- R7: A successful translation gives fault code 00 and physical address {frame, offset bits 11:0}.
- R8: On a successful store translation (`req_write` = 1), the segment first word is written back with bit 30 set if that bit was 0. After that, the page entry is written back with bit 30 set if that bit was 0. Loads, faults and entries already marked cause no write.
- R9: A memory request keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is seen. Read data may return on `mem_rvalid` any number of cycles (at least one) after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_tbl_base | input | 32 | Byte address of the segment table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_seg | input | 8 | Segment number |
| req_off | input | 24 | Byte offset within the segment |
| req_write | input | 1 | Request is for a store |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 00 ok, 01 segment absent, 10 bounds, 11 page absent |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A memory request is visible in the cycle after the state that issues it is entered. The next state is taken on the edge where `mem_rvalid` is seen, so a response is due one cycle after the last read data returns or the last write-back is accepted. Because memory latency and stalls are random, the bench never waits a fixed count. It drives inputs on falling edges, waits at falling edges for `rsp_valid`, and logs each memory request at the falling edge before the edge that accepts it. On each response it checks the fault code, the address, the number and addresses of reads, and each write-back. It also holds `rsp_ready` low for a random few cycles to check that the response does not move.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'b00,
    FLT_SEG_ABSENT  = 2'b01,
    FLT_LIMIT       = 2'b10,
    FLT_PAGE_ABSENT = 2'b11
  } fault_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEG0_RD,
    ST_SEG0_WT,
    ST_SEG1_RD,
    ST_SEG1_WT,
    ST_PTE_RD,
    ST_PTE_WT,
    ST_SEG_MARK,
    ST_PTE_MARK,
    ST_RESP
  } walk_e;

endpackage

// File: rtl/segx_addr_gen.sv
module segx_addr_gen #(
  parameter int AW    = 32,
  parameter int SEG_W = 8,
  parameter int PN_W  = 12
) (
  input  logic [AW-1:0]    tbl_base,
  input  logic [SEG_W-1:0] seg,
  input  logic [AW-1:0]    pt_base,
  input  logic [PN_W-1:0]  pn,
  output logic [AW-1:0]    seg_w0_addr,
  output logic [AW-1:0]    seg_w1_addr,
  output logic [AW-1:0]    pte_addr
);
  // two words per segment entry, one word per page entry
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  always_comb begin
    seg_w0_addr = tbl_base + {{(AW-SEG_W-3){1'b0}}, seg, 3'b000};
    seg_w1_addr = seg_w0_addr + WORD_STEP;
    pte_addr    = pt_base + {{(AW-PN_W-2){1'b0}}, pn, 2'b00};
  end
endmodule

// File: rtl/segx_entry_chk.sv
module segx_entry_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 24,
  parameter int PO_W  = 12
) (
  input  logic [DW-1:0]    seg_word,
  input  logic [LEN_W-1:0] off,
  input  logic [DW-1:0]    pte_word,
  output logic             seg_present,
  output logic             seg_dirty,
  output logic             in_bounds,
  output logic             pte_present,
  output logic             pte_dirty,
  output logic [AW-1:0]    xl_paddr,
  output logic [DW-1:0]    seg_marked,
  output logic [DW-1:0]    pte_marked
);
  localparam int PRES_BIT = DW - 1;
  localparam int MOD_BIT  = DW - 2;
  localparam int FRAME_W  = AW - PO_W;
  localparam logic [DW-1:0] MOD_MASK = {2'b01, {(DW-2){1'b0}}};

  always_comb begin
    seg_present = seg_word[PRES_BIT];
    seg_dirty   = seg_word[MOD_BIT];
    in_bounds   = off < seg_word[LEN_W-1:0];
    pte_present = pte_word[PRES_BIT];
    pte_dirty   = pte_word[MOD_BIT];
    xl_paddr    = {pte_word[FRAME_W-1:0], off[PO_W-1:0]};
    seg_marked  = seg_word | MOD_MASK;
    pte_marked  = pte_word | MOD_MASK;
  end
endmodule

// File: rtl/segx_xlate.sv
module segx_xlate
  import segx_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int PN_W  = 12,
  parameter int PO_W  = 12,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        seg_tbl_base,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEG_W-1:0]     req_seg,
  input  logic [PN_W+PO_W-1:0] req_off,
  input  logic                 req_write,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [AW-1:0]        rsp_paddr,
  output logic [1:0]           rsp_fault,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata
);
  localparam int LEN_W = PN_W + PO_W;

  walk_e             state_q, state_d;
  fault_e            fault_q, fault_d;
  logic [AW-1:0]     paddr_q, paddr_d;
  logic [DW-1:0]     segw_q, segw_d;
  logic [DW-1:0]     pte_q, pte_d;
  logic [AW-1:0]     ptb_q, ptb_d;
  logic [SEG_W-1:0]  seg_q;
  logic [LEN_W-1:0]  off_q;
  logic              we_q;
  logic [AW-1:0]     base_q;
  logic              accept;

  logic [AW-1:0] seg_w0_addr, seg_w1_addr, pte_addr;
  logic [DW-1:0] seg_word, pte_word, seg_marked, pte_marked;
  logic          seg_present, seg_dirty, in_bounds, pte_present, pte_dirty;
  logic [AW-1:0] xl_paddr;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  // the word just returned feeds the checks in the cycle it arrives
  assign seg_word = (state_q == ST_SEG0_WT) ? mem_rdata : segw_q;
  assign pte_word = (state_q == ST_PTE_WT)  ? mem_rdata : pte_q;

  segx_addr_gen #(.AW(AW), .SEG_W(SEG_W), .PN_W(PN_W)) u_addr (
    .tbl_base    (base_q),
    .seg         (seg_q),
    .pt_base     (ptb_q),
    .pn          (off_q[LEN_W-1:PO_W]),
    .seg_w0_addr (seg_w0_addr),
    .seg_w1_addr (seg_w1_addr),
    .pte_addr    (pte_addr)
  );

  segx_entry_chk #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .PO_W(PO_W)) u_chk_ent (
    .seg_word    (seg_word),
    .off         (off_q),
    .pte_word    (pte_word),
    .seg_present (seg_present),
    .seg_dirty   (seg_dirty),
    .in_bounds   (in_bounds),
    .pte_present (pte_present),
    .pte_dirty   (pte_dirty),
    .xl_paddr    (xl_paddr),
    .seg_marked  (seg_marked),
    .pte_marked  (pte_marked)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    paddr_d = paddr_q;
    segw_d  = segw_q;
    pte_d   = pte_q;
    ptb_d   = ptb_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SEG0_RD;
          fault_d = FLT_NONE;
          paddr_d = '0;
        end
      end
      ST_SEG0_RD: if (mem_ready) state_d = ST_SEG0_WT;
      ST_SEG0_WT: begin
        if (mem_rvalid) begin
          segw_d = mem_rdata;
          if (!seg_present) begin
            fault_d = FLT_SEG_ABSENT;
            state_d = ST_RESP;
          end else if (!in_bounds) begin
            fault_d = FLT_LIMIT;
            state_d = ST_RESP;
          end else begin
            state_d = ST_SEG1_RD;
          end
        end
      end
      ST_SEG1_RD: if (mem_ready) state_d = ST_SEG1_WT;
      ST_SEG1_WT: begin
        if (mem_rvalid) begin
          ptb_d   = mem_rdata[AW-1:0];
          state_d = ST_PTE_RD;
        end
      end
      ST_PTE_RD: if (mem_ready) state_d = ST_PTE_WT;
      ST_PTE_WT: begin
        if (mem_rvalid) begin
          pte_d = mem_rdata;
          if (!pte_present) begin
            fault_d = FLT_PAGE_ABSENT;
            state_d = ST_RESP;
          end else begin
            paddr_d = xl_paddr;
            if (we_q && !seg_dirty)      state_d = ST_SEG_MARK;
            else if (we_q && !pte_dirty) state_d = ST_PTE_MARK;
            else                         state_d = ST_RESP;
          end
        end
      end
      ST_SEG_MARK: if (mem_ready) state_d = pte_dirty ? ST_RESP : ST_PTE_MARK;
      ST_PTE_MARK: if (mem_ready) state_d = ST_RESP;
      ST_RESP:     if (rsp_ready) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // memory port drive
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_SEG0_RD: begin mem_valid = 1'b1; mem_addr = seg_w0_addr; end
      ST_SEG1_RD: begin mem_valid = 1'b1; mem_addr = seg_w1_addr; end
      ST_PTE_RD:  begin mem_valid = 1'b1; mem_addr = pte_addr;    end
      ST_SEG_MARK: begin
        mem_valid = 1'b1; mem_we = 1'b1;
        mem_addr  = seg_w0_addr; mem_wdata = seg_marked;
      end
      ST_PTE_MARK: begin
        mem_valid = 1'b1; mem_we = 1'b1;
        mem_addr  = pte_addr; mem_wdata = pte_marked;
      end
      default: ;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
      segw_q  <= '0;
      pte_q   <= '0;
      ptb_q   <= '0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      paddr_q <= paddr_d;
      segw_q  <= segw_d;
      pte_q   <= pte_d;
      ptb_q   <= ptb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= '0;
      off_q  <= '0;
      we_q   <= 1'b0;
      base_q <= '0;
    end else if (accept) begin
      seg_q  <= req_seg;
      off_q  <= req_off;
      we_q   <= req_write;
      base_q <= seg_tbl_base;
    end
  end
endmodule

// File: rtl/segx_xlate_chk.sv
module segx_xlate_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int PO_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PO_W-1:0] req_off_lo,
  input logic            req_write,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [AW-1:0]   rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata
);
  logic [PO_W-1:0] off_cap;
  logic            we_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cap <= '0;
      we_cap  <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_cap <= req_off_lo;
      we_cap  <= req_write;
    end
  end

  // R1
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R7
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == 2'b00) |-> rsp_paddr[PO_W-1:0] == off_cap);

  // R3
  flt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'b00) |-> rsp_paddr == '0);

  // R8
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> we_cap && !rsp_valid);

  // R8
  mark_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[DW-2] && (mem_addr[1:0] == 2'b00));
endmodule

bind segx_xlate segx_xlate_chk #(.AW(AW), .DW(DW), .PO_W(PO_W)) u_xlate_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_off_lo (req_off[PO_W-1:0]),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/segx_xlate_test.sv
module segx_xlate_test;
  logic        clk, rst_n;
  logic [31:0] seg_tbl_base;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_seg;
  logic [23:0] req_off;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  logic [31:0] tbl_t;
  int rd_n, wr_n;
  logic [31:0] rd_a [4];
  logic [31:0] wr_a [4];
  logic [31:0] wr_d [4];
  logic [31:0] exp_ra [3];
  logic [31:0] exp_wa [2];
  logic [31:0] exp_wd [2];

  segx_xlate uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mix(input logic [31:0] x);
    logic [31:0] v;
    v = x ^ (x >> 16);
    v = v * 32'h7feb352d;
    v = v ^ (v >> 15);
    v = v * 32'h846ca68b;
    return v ^ (v >> 16);
  endfunction

  function automatic logic seg_p(input logic [7:0] i);
    logic [31:0] h;
    h = mix({24'h0, i} + 32'd77);
    return h[2:0] != 3'b000;
  endfunction

  function automatic logic seg_m(input logic [7:0] i);
    logic [31:0] h;
    h = mix({24'h0, i} + 32'd77);
    return h[3];
  endfunction

  function automatic logic [23:0] seg_len(input logic [7:0] i);
    logic [31:0] h;
    h = mix({24'h0, i} + 32'd1000);
    return h[23:0] | 24'h1;
  endfunction

  // bench memory contents: segment table at tbl_t, page tables elsewhere
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] rel, h;
    logic [7:0]  i;
    rel = a - tbl_t;
    if (a >= tbl_t && rel < 32'd2048) begin
      i = rel[10:3];
      if (!rel[2]) return {seg_p(i), seg_m(i), 6'b0, seg_len(i)};
      return 32'h0100_0000 + {8'h0, i, 16'h0};
    end
    h = mix(a);
    return {h[31] | h[30], h[29], 10'b0, h[19:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: random acceptance and read latency
  initial begin
    logic        pend;
    int          lat;
    logic [31:0] paddr_r;
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    pend = 1'b0; lat = 0; paddr_r = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(paddr_r);
          pend = 1'b0;
        end else lat--;
      end
      if (pend || mem_rvalid) mem_ready = 1'b0;
      else mem_ready = ($urandom % 4) != 0;
      if (mem_valid && mem_ready && rst_n) begin
        if (mem_we) begin
          if (wr_n < 4) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
          wr_n++;
        end else begin
          if (rd_n < 4) rd_a[rd_n] = mem_addr;
          rd_n++;
          pend = 1'b1; paddr_r = mem_addr; lat = $urandom % 4;
        end
      end
    end
  end

  task automatic do_x(input logic [7:0] s, input logic [23:0] off, input logic we, input bit scramble);
    logic [31:0] w0, ptb, pa, pte, ep, hp, seg0;
    logic [1:0]  ef, hf;
    int          enr, enw;
    string       ftag;
    seg0 = tbl_t + {21'h0, s, 3'b000};
    w0 = mem_word(seg0);
    ep = '0; enw = 0;
    exp_ra[0] = seg0;
    if (!w0[31]) begin ef = 2'b01; enr = 1; end
    else if (off >= w0[23:0]) begin ef = 2'b10; enr = 1; end
    else begin
      ptb = mem_word(seg0 + 32'd4);
      pa  = ptb + {18'h0, off[23:12], 2'b00};
      pte = mem_word(pa);
      exp_ra[1] = seg0 + 32'd4; exp_ra[2] = pa; enr = 3;
      if (!pte[31]) ef = 2'b11;
      else begin
        ef = 2'b00; ep = {pte[19:0], off[11:0]};
        if (we && !w0[30])  begin exp_wa[enw] = seg0; exp_wd[enw] = w0 | 32'h4000_0000; enw++; end
        if (we && !pte[30]) begin exp_wa[enw] = pa;   exp_wd[enw] = pte | 32'h4000_0000; enw++; end
      end
    end
    case (ef)
      2'b01: ftag = "R3 segment absent";
      2'b10: ftag = "R4 bounds";
      2'b11: ftag = "R6 page absent";
      default: ftag = "R7 translated";
    endcase

    rd_n = 0; wr_n = 0;
    req_seg = s; req_off = off; req_write = we; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) seg_tbl_base = 32'hDEAD_0000;
    while (!rsp_valid) @(negedge clk);
    hp = rsp_paddr; hf = rsp_fault;
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == hp && rsp_fault == hf, "R1 response held", rsp_paddr, hp);
    end
    chk(rsp_fault == ef, {ftag, " fault code"}, {30'h0, rsp_fault}, {30'h0, ef});
    chk(rsp_paddr == ep, {ftag, " paddr"}, rsp_paddr, ep);
    chk(rd_n == enr, "R4 R9 read count", rd_n, enr);
    for (int k = 0; k < enr && k < rd_n; k++) begin
      if (k < 2) chk(rd_a[k] == exp_ra[k], "R2 segment entry address", rd_a[k], exp_ra[k]);
      else       chk(rd_a[k] == exp_ra[k], "R5 page entry address", rd_a[k], exp_ra[k]);
    end
    chk(wr_n == enw, "R8 write-back count", wr_n, enw);
    for (int k = 0; k < enw && k < wr_n; k++) begin
      chk(wr_a[k] == exp_wa[k], "R8 write-back address", wr_a[k], exp_wa[k]);
      chk(wr_d[k] == exp_wd[k], "R8 write-back data", wr_d[k], exp_wd[k]);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    seg_tbl_base = tbl_t;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  s;
    logic [23:0] len, off;
    bit          found;
    void'($urandom(32'h5eed_0042));
    tbl_t = 32'h0000_2000;
    seg_tbl_base = tbl_t;
    req_valid = 1'b0; req_seg = '0; req_off = '0; req_write = 1'b0;
    rsp_ready = 1'b0; rd_n = 0; wr_n = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 reset req_ready", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk(mem_valid == 1'b0, "R9 reset mem_valid", {31'h0, mem_valid}, 32'h0);

    // R3 absent segment wins over a bounds violation
    found = 1'b0;
    for (int i = 0; i < 256 && !found; i++)
      if (!seg_p(8'(i))) begin do_x(8'(i), 24'hFFFFFF, 1'b1, 1'b0); found = 1'b1; end

    // R4 boundary: offset equal to the length and one below
    found = 1'b0;
    for (int i = 0; i < 256 && !found; i++)
      if (seg_p(8'(i))) begin
        len = seg_len(8'(i));
        do_x(8'(i), len, 1'b1, 1'b0);
        do_x(8'(i), len - 24'd1, 1'b1, 1'b0);
        do_x(8'(i), 24'd0, 1'b0, 1'b1);
        found = 1'b1;
      end

    // R6 absent page inside a large segment
    found = 1'b0;
    for (int i = 0; i < 256 && !found; i++)
      if (seg_p(8'(i)) && seg_len(8'(i)) > 24'h10_0000)
        for (int pn = 0; pn < 256 && !found; pn++) begin
          if (!mem_word(32'h0100_0000 + {8'h0, 8'(i), 16'h0} + 32'(pn * 4))[31]) begin
            do_x(8'(i), {12'(pn), 12'h345}, 1'b1, 1'b0);
            found = 1'b1;
          end
        end

    // R8 store into segments with the modified flag clear and set
    for (int v = 0; v < 2; v++) begin
      found = 1'b0;
      for (int i = 0; i < 256 && !found; i++)
        if (seg_p(8'(i)) && seg_m(8'(i)) == v[0]) begin
          do_x(8'(i), 24'h000ABC % seg_len(8'(i)), 1'b1, 1'b0);
          found = 1'b1;
        end
    end

    // random traffic, second half with a relocated segment table (R2)
    for (int n = 0; n < 300; n++) begin
      if (n == 150) begin tbl_t = 32'h0040_0000; seg_tbl_base = tbl_t; end
      s = 8'($urandom);
      len = seg_len(s);
      if ($urandom % 2 == 0) off = 24'($urandom);
      else off = 24'($urandom % {8'h0, len});
      do_x(s, off, 1'($urandom), ($urandom % 4) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule